// File: doc/BRIEF.md
# Doorbell Interrupt Unit

This block collects doorbell events for a small group of CPUs and turns them into interrupt lines. Any agent can write one shared trigger word: the lowest five bits name one of 32 doorbells, and a bitmap that starts at bit 8 names the CPUs that should receive it. The named doorbell bit is then set in the pending register of each selected CPU. A PCI message-signalled interrupt aimed at the same trigger address carries a data word of 0xF00 OR (16 + vector). Because bits 8 to 11 are all set in that word, every CPU receives doorbell 16 + vector.

Each CPU has a pending (cause) register and an enable (mask) register. Software services an event by reading the pending bits and writing back their bitwise inverse. A bit written as 0 is cleared and a bit written as 1 is kept. Two summary lines leave the block for each CPU. The first covers the inter-processor doorbells 0 to 7. The second covers the message doorbells 16 to 31. Doorbells 8 to 15 can still be stored and read back.

Top module: `doorbell_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every pending and every enable register becomes zero, so all summary lines are low and every read returns zero.
- R2: A trigger write sets pending bit trig_wdata[4:0] in the register of each CPU c for which trig_wdata[8+c] is 1. The registers of the other CPUs do not change.
- R3: Bits 7:5 of the trigger word, and bitmap bits that name CPUs at or above NCPU, have no effect.
- R4: A pending-register write (reg_sel = 0) to CPU reg_cpu keeps the bits written as 1 and clears the bits written as 0. A write of zero clears every pending bit of that CPU.
- R5: An enable-register write (reg_sel = 1) replaces the enable register of CPU reg_cpu. rd_data returns the register selected by rd_sel (0 for pending, 1 for enable) of CPU rd_cpu.
- R6: ipi_irq[c] is high exactly while pending AND enable AND 0x000000FF is nonzero for CPU c.
- R7: msi_irq[c] is high exactly while pending AND enable AND 0xFFFF0000 is nonzero for CPU c.
- R8: Pending doorbells 8 to 15 drive neither summary line, even when they are enabled.
- R9: When a trigger write and a pending-register write to the same CPU fall in one cycle, the triggered bit ends up set, even if the write had cleared it.
- R10: A message write with data 0xF00 OR (16 + i) sets doorbell 16 + i on all four CPUs of the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_wdata | input | 32 | Trigger word: doorbell number [4:0], CPU bitmap from bit 8 |
| reg_we | input | 1 | Per-CPU register write strobe |
| reg_sel | input | 1 | 0 selects the pending register, 1 selects the enable register |
| reg_cpu | input | CW | CPU whose register is written |
| reg_wdata | input | 32 | Write data for the per-CPU register |
| rd_sel | input | 1 | Read select: 0 pending, 1 enable |
| rd_cpu | input | CW | CPU whose register is read |
| rd_data | output | 32 | Read data |
| ipi_irq | output | NCPU | Inter-processor summary interrupt, one per CPU |
| msi_irq | output | NCPU | Message summary interrupt, one per CPU |

## Verification
The bench tests clear-by-inverse writes that mix cleared and kept bits. A design that simply stored the written word would leave stray pending bits set, and a design that cleared on 1 would wipe out events that had not been serviced. It sends trigger words with junk in bits 7:5, and bitmaps that name only CPUs that do not exist. A decoder that is too wide would then set the wrong doorbell or an out-of-range entry. It enables doorbells 8 to 15 with one of them pending, which catches a group mask that is too wide and raises a summary line. It also fires a trigger in the same cycle as a full clear on that CPU, where a design that lets the clear win would lose the event.

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
  parameter int NCPU = 4,
  parameter logic [31:0] IPI_GROUP = 32'h0000_00FF,
  parameter logic [31:0] MSI_GROUP = 32'hFFFF_0000,
  parameter int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_we,
  input  logic [31:0]     trig_wdata,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [CW-1:0]   reg_cpu,
  input  logic [31:0]     reg_wdata,
  input  logic            rd_sel,
  input  logic [CW-1:0]   rd_cpu,
  output logic [31:0]     rd_data,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] msi_irq
);

  localparam int MAP_LSB = 8;
  localparam int MAP_MSB = MAP_LSB + NCPU - 1;

  logic [NCPU-1:0][31:0] cause_q, mask_q;
  logic [NCPU-1:0][31:0] set_v, keep_v;
  logic [NCPU-1:0]       mask_wr;
  logic [31:0]           bell_onehot;

  assign bell_onehot = 32'd1 << trig_wdata[4:0];

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      set_v[c]   = (trig_we && trig_wdata[MAP_LSB + c]) ? bell_onehot : 32'd0;
      keep_v[c]  = (reg_we && !reg_sel && reg_cpu == CW'(c)) ? reg_wdata : '1;
      mask_wr[c] = reg_we && reg_sel && reg_cpu == CW'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        cause_q[c] <= (cause_q[c] & keep_v[c]) | set_v[c];
        if (mask_wr[c]) mask_q[c] <= reg_wdata;
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_sum
    assign ipi_irq[c] = |(cause_q[c] & mask_q[c] & IPI_GROUP);
    assign msi_irq[c] = |(cause_q[c] & mask_q[c] & MSI_GROUP);
  end

  assign rd_data = rd_sel ? mask_q[rd_cpu] : cause_q[rd_cpu];

  logic unused_trig_bits;
  assign unused_trig_bits = ^{trig_wdata[7:5], trig_wdata[31:MAP_MSB+1]};

endmodule

// File: rtl/doorbell_unit_chk.sv
module doorbell_unit_chk #(
  parameter int NCPU = 4,
  parameter int CW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trig_we,
  input logic [31:0]           trig_wdata,
  input logic                  reg_we,
  input logic                  reg_sel,
  input logic [CW-1:0]         reg_cpu,
  input logic [31:0]           reg_wdata,
  input logic [NCPU-1:0][31:0] cause,
  input logic [NCPU-1:0][31:0] mask,
  input logic [NCPU-1:0]       ipi_irq,
  input logic [NCPU-1:0]       msi_irq
);

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    assert_trig_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_we && trig_wdata[8+c] |=> cause[c][$past(trig_wdata[4:0])]);

    assert_cause_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_we && !(reg_we && !reg_sel) |=> $stable(cause[c]));

    assert_clear_by_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && !reg_sel && reg_cpu == CW'(c) && !trig_we
      |=> cause[c] == ($past(cause[c]) & $past(reg_wdata)));

    assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_sel && reg_cpu == CW'(c) |=> mask[c] == $past(reg_wdata));

    assert_ipi_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_irq[c] |-> (cause[c][7:0] & mask[c][7:0]) != 8'd0);

    assert_msi_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msi_irq[c] |-> (cause[c][31:16] & mask[c][31:16]) != 16'd0);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_we && trig_wdata[8+c] && reg_we && !reg_sel && reg_cpu == CW'(c)
      |=> cause[c][$past(trig_wdata[4:0])]);
  end

endmodule

bind doorbell_unit doorbell_unit_chk #(.NCPU(NCPU)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
  .reg_we(reg_we), .reg_sel(reg_sel), .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
  .cause(cause_q), .mask(mask_q), .ipi_irq(ipi_irq), .msi_irq(msi_irq)
);

// File: tb/doorbell_unit_tb_top.sv
module doorbell_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_we = 1'b0;
  logic [31:0] trig_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [1:0]  reg_cpu = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_sel = 1'b0;
  logic [1:0]  rd_cpu = '0;
  logic [31:0] rd_data;
  logic [3:0]  ipi_irq, msi_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  doorbell_unit dut_i (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_wdata(trig_wdata),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_cpu(rd_cpu), .rd_data(rd_data),
    .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  // op: 0 trigger, 1 pending write, 2 enable write
  // fields: op, cpu, data, check cpu, expected pending, expected ipi, expected msi
  localparam int NV = 14;
  localparam logic [77:0] VEC [NV] = '{
    {2'd2, 2'd0, 32'h0000_00FF, 2'd0, 32'h0000_0000, 4'b0000, 4'b0000}, // R5
    {2'd2, 2'd1, 32'hFFFF_0000, 2'd1, 32'h0000_0000, 4'b0000, 4'b0000}, // R5
    {2'd2, 2'd2, 32'hFFFF_00FF, 2'd2, 32'h0000_0000, 4'b0000, 4'b0000}, // R5
    {2'd0, 2'd0, 32'h0000_0103, 2'd0, 32'h0000_0008, 4'b0001, 4'b0000}, // R2 R6
    {2'd0, 2'd0, 32'h0000_0605, 2'd1, 32'h0000_0020, 4'b0101, 4'b0000}, // R2 R6
    {2'd0, 2'd0, 32'h0000_0F14, 2'd3, 32'h0010_0000, 4'b0101, 4'b0110}, // R10 R7
    {2'd1, 2'd1, 32'hFFFF_FFDF, 2'd1, 32'h0010_0000, 4'b0101, 4'b0110}, // R4
    {2'd0, 2'd0, 32'h0000_01EA, 2'd0, 32'h0010_0408, 4'b0101, 4'b0110}, // R3
    {2'd1, 2'd0, 32'hFFFF_FFF7, 2'd0, 32'h0010_0400, 4'b0100, 4'b0110}, // R4 R6
    {2'd2, 2'd0, 32'h0000_FF00, 2'd0, 32'h0010_0400, 4'b0100, 4'b0110}, // R8
    {2'd0, 2'd0, 32'h0000_F01F, 2'd3, 32'h0010_0000, 4'b0100, 4'b0110}, // R3
    {2'd0, 2'd0, 32'h0000_081F, 2'd3, 32'h8010_0000, 4'b0100, 4'b0110}, // R2 R7
    {2'd2, 2'd3, 32'h8000_0000, 2'd3, 32'h8010_0000, 4'b0100, 4'b1110}, // R7
    {2'd1, 2'd2, 32'h0000_0000, 2'd2, 32'h0000_0000, 4'b0000, 4'b1010}  // R4
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] cpu, input logic sel, output logic [31:0] val);
    rd_cpu = cpu;
    rd_sel = sel;
    #1 val = rd_data;
  endtask

  task automatic check_all_zero(string tag);
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      read_reg(2'(c), 1'b0, v);
      check(tag, v, 32'h0);
      read_reg(2'(c), 1'b1, v);
      check(tag, v, 32'h0);
    end
    check(tag, {28'd0, ipi_irq}, 32'h0);
    check(tag, {28'd0, msi_irq}, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all_zero("R1 reset state");

    for (int i = 0; i < NV; i++) begin
      logic [77:0] e;
      e = VEC[i];
      @(negedge clk);
      case (e[77:76])
        2'd0: begin trig_we = 1'b1; trig_wdata = e[73:42]; end
        2'd1: begin reg_we = 1'b1; reg_sel = 1'b0; reg_cpu = e[75:74]; reg_wdata = e[73:42]; end
        default: begin reg_we = 1'b1; reg_sel = 1'b1; reg_cpu = e[75:74]; reg_wdata = e[73:42]; end
      endcase
      @(negedge clk);
      trig_we = 1'b0;
      reg_we = 1'b0;
      read_reg(e[41:40], 1'b0, v);
      check($sformatf("vector %0d pending", i), v, e[39:8]);
      check($sformatf("vector %0d ipi", i), {28'd0, ipi_irq}, {28'd0, e[7:4]});
      check($sformatf("vector %0d msi", i), {28'd0, msi_irq}, {28'd0, e[3:0]});
    end

    // R5 enable register read back
    read_reg(2'd3, 1'b1, v);
    check("R5 enable readback cpu3", v, 32'h8000_0000);

    // R9 trigger bell 20 to cpu1 while a full clear hits cpu1
    @(negedge clk);
    trig_we = 1'b1; trig_wdata = 32'h0000_0214;
    reg_we = 1'b1; reg_sel = 1'b0; reg_cpu = 2'd1; reg_wdata = 32'h0;
    @(negedge clk);
    trig_we = 1'b0; reg_we = 1'b0;
    read_reg(2'd1, 1'b0, v);
    check("R9 set wins over clear", v, 32'h0010_0000);
    check("R9 msi cpu1 stays", {31'd0, msi_irq[1]}, 32'd1);

    // R8 doorbell 15 enabled on cpu0, no summary line
    @(negedge clk);
    trig_we = 1'b1; trig_wdata = 32'h0000_010F;
    @(negedge clk);
    trig_we = 1'b0;
    check("R8 bell 15 no ipi", {31'd0, ipi_irq[0]}, 32'd0);
    check("R8 bell 15 no msi", {31'd0, msi_irq[0]}, 32'd0);

    // R1 reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_all_zero("R1 mid-run reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule